// File: doc/BRIEF.md
# Byte-Synchronous Serial Transmitter with Underrun Handling

This block sends byte-oriented synchronous messages on a single serial line. The host hands bytes in over a valid/ready stream into a one-byte holding buffer. The sequencer opens each message with two programmable sync characters, then shifts the data bytes out least significant bit first, one bit for each bit-clock enable. At the end of a message it can append a 16-bit CRC. When no message is running, the line either rests at logic one or repeats a programmable idle character.

A message ends in one of two ways. The host may issue an end-of-message command. Otherwise the buffer runs dry, which is an underrun. An underrun sets a sticky flag and closes the input stream. Depending on two control bits, the transmitter either appends the CRC or falls straight back to idle. It starts no new message until software clears the flag with a write-one pulse and offers a fresh byte.

Back-pressure rule: `s_ready` is high only when the holding buffer is empty, the transmitter is enabled and no underrun is flagged. A byte is taken on any clock edge where `s_valid` and `s_ready` are both high. While `s_ready` is low, the host must hold `s_valid` and `s_data` until the transfer completes. `s_ready` also serves as the transmit-ready flag.

Top module: `bsync_tx`

## Requirements
- R1: After reset, `txd` is 1, `udr_flag`, `eom_flag` and `irq` are 0, and `s_ready` is 1 while `tx_en` is 1.
- R2: While idle, `txd` stays 1 when `idle_sel` is 0. When `idle_sel` is 1, `txd` repeats `idle_pat` LSB first. An idle character always lasts 8 bit enables.
- R3: `txd` is registered and changes only on a clock edge where `bit_en` is 1. A message starts only at the end of an idle character. It starts when the buffer holds a byte, `tx_en` is 1 and `udr_flag` is 0. It sends `sync_a`, then `sync_b`, then the data bytes in the order accepted, each LSB first.
- R4: `s_ready` equals (buffer empty AND `tx_en` AND NOT `udr_flag`). A byte offered while `s_ready` is 0 is not taken and is not transmitted.
- R5: On end of message with `crc_en`=1, 16 CRC bits follow the last data byte, most significant bit first, and then the line goes idle. The CRC uses polynomial 0x1021 and is preset to 0xFFFF at the first data byte. It is updated with each data bit in line order, with feedback = crc[15] XOR bit. Sync characters are not included.
- R6: On end of message with `crc_en`=0, the line goes idle right after the last data byte. `eom_flag` is set, and `irq` is raised if `eom_ie` is 1.
- R7: An underrun occurs when a data byte ends with the buffer empty and no end-of-message command pending. It sets `udr_flag`, drops `s_ready`, and raises `irq` if `udr_ie` is 1.
- R8: On underrun, the CRC is sent before idle only if `udr_crc_en` and `crc_en` are both 1; otherwise idle follows at once. With `udr_crc_en`=1 the underrun also counts as an end of message, so with `crc_en`=0 it sets `eom_flag` as well.
- R9: `udr_flag` stays set until a cycle with `st_clr[0]`=1. While it is set, no byte is taken and no message starts. After it clears, a written byte starts a new message with `sync_a`.
- R10: `eom_cmd` pulses that arrive while no message is in its sync or data phase are ignored.
- R11: A byte waiting in the buffer takes priority over a pending end-of-message command. The message ends only after the buffer has drained.
- R12: `st_clr` bit 0 clears only `udr_flag` and bit 1 clears only `eom_flag`. A flag that is set in the same cycle as its clear stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_en | input | 1 | Transmitter enable |
| bit_en | input | 1 | Bit-clock enable, one line bit per pulse |
| crc_en | input | 1 | Append CRC at end of message |
| udr_crc_en | input | 1 | Treat underrun as end of message |
| idle_sel | input | 1 | 0: idle line high, 1: send idle pattern |
| idle_pat | input | 8 | Idle character |
| sync_a | input | 8 | First sync character |
| sync_b | input | 8 | Second sync character |
| udr_ie | input | 1 | Underrun interrupt enable |
| eom_ie | input | 1 | End-of-message interrupt enable |
| s_valid | input | 1 | Input byte valid |
| s_data | input | 8 | Input byte |
| s_ready | output | 1 | Buffer can accept (transmit-ready) |
| eom_cmd | input | 1 | End-of-message command pulse |
| st_clr | input | 2 | Write-one-to-clear: bit 0 underrun, bit 1 end of message |
| txd | output | 1 | Serial data line |
| udr_flag | output | 1 | Sticky underrun status |
| eom_flag | output | 1 | Sticky end-of-message-without-CRC status |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situation to reach is where an end-of-message command and a waiting byte meet at a character boundary. Also hard is an underrun whose outcome depends on both control bits together with the sticky flag. The stimulus reaches the first by issuing the command while a later byte still sits in the buffer, then feeding one more byte as the buffer drains. It reaches the second by starving the buffer under each combination of the two control bits. It also offers bytes while the flag is set, before clearing it and restarting. A bit-level model in the bench follows every edge, so a wrong decision shows up on the line or on a flag.

// File: rtl/bsync_tx_pkg.sv
package bsync_tx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_SYN1 = 3'd1,
    ST_SYN2 = 3'd2,
    ST_DATA = 3'd3,
    ST_CRC  = 3'd4
  } tx_state_e;

  localparam int unsigned FLAG_UDR = 0;
  localparam int unsigned FLAG_EOM = 1;
  localparam int unsigned N_FLAGS  = 2;
endpackage

// File: rtl/bstx_holdbuf.sv
module bstx_holdbuf #(
  parameter int unsigned CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en,
  input  logic              udr_flag,
  input  logic              s_valid,
  input  logic [CHAR_W-1:0] s_data,
  output logic              s_ready,
  input  logic              take,
  output logic              full,
  output logic [CHAR_W-1:0] data
);
  logic accept;

  assign s_ready = !full && tx_en && !udr_flag;
  assign accept  = s_valid && s_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full <= 1'b0;
      data <= '0;
    end else begin
      if (take) full <= 1'b0;
      if (accept) begin
        full <= 1'b1;
        data <= s_data;
      end
    end
  end

  // R4: an accepted byte occupies the buffer on the next cycle
  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready) |=> full);

  // R4: a held byte is never altered while it waits
  p_hold_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !take) |=> (full && $stable(data)));
endmodule

// File: rtl/bstx_crc.sv
module bstx_crc #(
  parameter int unsigned CRC_W    = 16,
  parameter logic [CRC_W-1:0] CRC_POLY = 16'h1021,
  parameter logic [CRC_W-1:0] CRC_INIT = 16'hFFFF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init,
  input  logic             step,
  input  logic             din,
  output logic [CRC_W-1:0] crc
);
  logic             fb;
  logic [CRC_W-1:0] shifted;

  assign fb      = crc[CRC_W-1] ^ din;
  assign shifted = {crc[CRC_W-2:0], 1'b0};

  always_ff @(posedge clk) begin
    if (!rst_n)    crc <= CRC_INIT;
    else if (init) crc <= CRC_INIT;
    else if (step) crc <= fb ? (shifted ^ CRC_POLY) : shifted;
  end

  // R5: preset and update never coincide
  p_init_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(init && step));
endmodule

// File: rtl/bstx_seq.sv
module bstx_seq
  import bsync_tx_pkg::*;
#(
  parameter int unsigned CHAR_W = 8,
  parameter int unsigned CRC_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic              tx_en,
  input  logic              crc_en,
  input  logic              udr_crc_en,
  input  logic              idle_sel,
  input  logic [CHAR_W-1:0] idle_pat,
  input  logic [CHAR_W-1:0] sync_a,
  input  logic [CHAR_W-1:0] sync_b,
  input  logic              buf_full,
  input  logic [CHAR_W-1:0] buf_data,
  input  logic              eom_cmd,
  input  logic              udr_flag,
  input  logic [CRC_W-1:0]  crc_val,
  output logic              take,
  output logic              crc_init,
  output logic              crc_step,
  output logic              crc_bit,
  output logic              ev_udr,
  output logic              ev_eom,
  output logic              txd
);
  localparam int unsigned MAX_LEN = (CRC_W > CHAR_W) ? CRC_W : CHAR_W;
  localparam int unsigned CNT_W   = $clog2(MAX_LEN);
  localparam int unsigned IDX_W   = $clog2(CHAR_W);

  tx_state_e         state, nxt_state;
  logic [CNT_W-1:0]  bcnt;
  logic [CHAR_W-1:0] shreg, load_val;
  logic              eom_pend;
  logic              active, eom_now, last, char_end, cur_bit, consume;
  logic [IDX_W-1:0]  cidx;
  logic [CNT_W-1:0]  crc_idx;

  assign active   = (state == ST_SYN1) || (state == ST_SYN2) || (state == ST_DATA);
  assign eom_now  = eom_pend || (eom_cmd && active);
  assign last     = (state == ST_CRC) ? (bcnt == CNT_W'(CRC_W - 1))
                                      : (bcnt == CNT_W'(CHAR_W - 1));
  assign char_end = bit_en && last;
  assign cidx     = bcnt[IDX_W-1:0];
  assign crc_idx  = CNT_W'(CRC_W - 1) - bcnt;
  assign crc_step = bit_en && (state == ST_DATA);
  assign crc_bit  = shreg[cidx];

  always_comb begin
    case (state)
      ST_IDLE: cur_bit = idle_sel ? idle_pat[cidx] : 1'b1;
      ST_CRC:  cur_bit = crc_val[crc_idx];
      default: cur_bit = shreg[cidx];
    endcase
  end

  always_comb begin
    nxt_state = state;
    load_val  = shreg;
    take      = 1'b0;
    crc_init  = 1'b0;
    ev_udr    = 1'b0;
    ev_eom    = 1'b0;
    consume   = 1'b0;
    if (char_end) begin
      case (state)
        ST_IDLE: begin
          if (buf_full && !udr_flag && tx_en) begin
            nxt_state = ST_SYN1;
            load_val  = sync_a;
          end
        end
        ST_SYN1: begin
          nxt_state = ST_SYN2;
          load_val  = sync_b;
        end
        ST_SYN2: begin
          nxt_state = ST_DATA;
          load_val  = buf_data;
          take      = 1'b1;
          crc_init  = 1'b1;
        end
        ST_DATA: begin
          if (buf_full) begin
            load_val = buf_data;
            take     = 1'b1;
          end else if (eom_now) begin
            consume   = 1'b1;
            nxt_state = crc_en ? ST_CRC : ST_IDLE;
            ev_eom    = !crc_en;
          end else begin
            consume   = 1'b1;
            ev_udr    = 1'b1;
            nxt_state = (udr_crc_en && crc_en) ? ST_CRC : ST_IDLE;
            ev_eom    = udr_crc_en && !crc_en;
          end
        end
        ST_CRC:  nxt_state = ST_IDLE;
        default: nxt_state = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      bcnt     <= '0;
      shreg    <= '0;
      eom_pend <= 1'b0;
      txd      <= 1'b1;
    end else begin
      state <= nxt_state;
      shreg <= load_val;
      if (bit_en) begin
        txd  <= cur_bit;
        bcnt <= last ? '0 : bcnt + CNT_W'(1);
      end
      if (consume)               eom_pend <= 1'b0;
      else if (eom_cmd && active) eom_pend <= 1'b1;
    end
  end

  // R2: a marking idle line stays high after each idle bit
  p_idle_mark_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && state == ST_IDLE && !idle_sel) |=> txd);

  // R9: no message starts while the underrun flag is up
  p_hold_in_udr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && udr_flag) |=> (state == ST_IDLE));

  // R3: the buffer is only drained when it holds a byte
  p_take_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> buf_full);

  // R3: the line moves only on bit enables
  p_txd_on_bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(txd));
endmodule

// File: rtl/bstx_status.sv
module bstx_status
  import bsync_tx_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_FLAGS-1:0] set,
  input  logic [N_FLAGS-1:0] clr,
  input  logic [N_FLAGS-1:0] ie,
  output logic [N_FLAGS-1:0] flags,
  output logic               irq
);
  for (genvar g = 0; g < N_FLAGS; g++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n)      flags[g] <= 1'b0;
      else if (set[g]) flags[g] <= 1'b1;
      else if (clr[g]) flags[g] <= 1'b0;
    end

    // R12 (and R9 for the underrun flag): only a clear pulse drops a flag
    p_flag_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (flags[g] && !clr[g]) |=> flags[g]);

    // R7 / R6: an event always leaves its flag set
    p_flag_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
      set[g] |=> flags[g]);
  end

  assign irq = |(flags & ie);
endmodule

// File: rtl/bsync_tx.sv
module bsync_tx
  import bsync_tx_pkg::*;
#(
  parameter int unsigned CHAR_W = 8,
  parameter int unsigned CRC_W  = 16,
  parameter logic [CRC_W-1:0] CRC_POLY = 16'h1021,
  parameter logic [CRC_W-1:0] CRC_INIT = 16'hFFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en,
  input  logic              bit_en,
  input  logic              crc_en,
  input  logic              udr_crc_en,
  input  logic              idle_sel,
  input  logic [CHAR_W-1:0] idle_pat,
  input  logic [CHAR_W-1:0] sync_a,
  input  logic [CHAR_W-1:0] sync_b,
  input  logic              udr_ie,
  input  logic              eom_ie,
  input  logic              s_valid,
  input  logic [CHAR_W-1:0] s_data,
  output logic              s_ready,
  input  logic              eom_cmd,
  input  logic [1:0]        st_clr,
  output logic              txd,
  output logic              udr_flag,
  output logic              eom_flag,
  output logic              irq
);
  logic              take, buf_full;
  logic [CHAR_W-1:0] buf_data;
  logic              crc_init, crc_step, crc_bit;
  logic [CRC_W-1:0]  crc_val;
  logic              ev_udr, ev_eom;
  logic [N_FLAGS-1:0] flags;

  bstx_holdbuf #(.CHAR_W(CHAR_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .udr_flag(udr_flag),
    .s_valid(s_valid), .s_data(s_data), .s_ready(s_ready),
    .take(take), .full(buf_full), .data(buf_data)
  );

  bstx_crc #(.CRC_W(CRC_W), .CRC_POLY(CRC_POLY), .CRC_INIT(CRC_INIT)) u_crc (
    .clk(clk), .rst_n(rst_n), .init(crc_init), .step(crc_step),
    .din(crc_bit), .crc(crc_val)
  );

  bstx_seq #(.CHAR_W(CHAR_W), .CRC_W(CRC_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .tx_en(tx_en),
    .crc_en(crc_en), .udr_crc_en(udr_crc_en), .idle_sel(idle_sel),
    .idle_pat(idle_pat), .sync_a(sync_a), .sync_b(sync_b),
    .buf_full(buf_full), .buf_data(buf_data), .eom_cmd(eom_cmd),
    .udr_flag(udr_flag), .crc_val(crc_val), .take(take),
    .crc_init(crc_init), .crc_step(crc_step), .crc_bit(crc_bit),
    .ev_udr(ev_udr), .ev_eom(ev_eom), .txd(txd)
  );

  bstx_status u_stat (
    .clk(clk), .rst_n(rst_n),
    .set({ev_eom, ev_udr}), .clr(st_clr), .ie({eom_ie, udr_ie}),
    .flags(flags), .irq(irq)
  );

  assign udr_flag = flags[FLAG_UDR];
  assign eom_flag = flags[FLAG_EOM];

  // R7: an underrun closes the input stream on the following cycle
  p_udr_closes_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_udr |=> !s_ready);
endmodule

// File: tb/bsync_tx_test.sv
module bsync_tx_test;
  logic clk = 1'b0;
  logic rst_n, tx_en, bit_en, crc_en, udr_crc_en, idle_sel, udr_ie, eom_ie;
  logic [7:0] idle_pat, sync_a, sync_b, s_data;
  logic s_valid, s_ready, eom_cmd, txd, udr_flag, eom_flag, irq;
  logic [1:0] st_clr;

  always #2 clk = ~clk;

  bsync_tx uut (.*);

  int n_cmp = 0, n_bad = 0;
  string phase = "R1";
  int bdiv = 1, bcnt_g = 0;

  // bit enable generator
  initial begin
    bit_en = 1'b1;
    forever begin
      @(negedge clk);
      if (bdiv <= 1) bit_en = 1'b1;
      else begin
        bcnt_g = (bcnt_g + 1) % bdiv;
        bit_en = (bcnt_g == 0);
      end
    end
  end

  // ---------------- reference model ----------------
  int mk = 0;           // 0 idle, 1 sync a, 2 sync b, 3 data, 4 crc
  int ipos = 0;
  bit q[$];
  logic m_full = 0, m_udr = 0, m_eomf = 0, m_pend = 0, m_txd = 1;
  logic [7:0] m_data = 0;
  logic [15:0] m_crc = 16'hFFFF;
  bit acc_evt = 0;

  function automatic logic [15:0] crc_next(logic [15:0] c, logic b);
    logic [15:0] s = c << 1;
    if (c[15] != b) s = s ^ 16'h1021;
    return s;
  endfunction

  task automatic q_byte(logic [7:0] b);
    for (int i = 0; i < 8; i++) q.push_back(b[i]);
  endtask

  task automatic q_crc(logic [15:0] c);
    for (int i = 15; i >= 0; i--) q.push_back(c[i]);
  endtask

  always @(posedge clk) begin
    logic rdy, act, ecmd, tk, eu, ee, done;
    if (!rst_n) begin
      mk = 0; ipos = 0; q.delete(); m_full = 0; m_udr = 0; m_eomf = 0;
      m_pend = 0; m_txd = 1; m_data = 0; m_crc = 16'hFFFF; acc_evt = 0;
    end else begin
      rdy  = !m_full && tx_en && !m_udr;
      act  = (mk >= 1 && mk <= 3);
      ecmd = eom_cmd && act;
      tk = 0; eu = 0; ee = 0; done = 0;
      if (bit_en) begin
        if (mk == 0) begin
          m_txd = idle_sel ? idle_pat[ipos] : 1'b1;
          ipos++;
          done = (ipos == 8);
        end else begin
          m_txd = q.pop_front();
          if (mk == 3) m_crc = crc_next(m_crc, m_txd);
          done = (q.size() == 0);
        end
        if (done) begin
          case (mk)
            0: begin
              ipos = 0;
              if (m_full && !m_udr && tx_en) begin mk = 1; q_byte(sync_a); end
            end
            1: begin mk = 2; q_byte(sync_b); end
            2: begin mk = 3; m_crc = 16'hFFFF; q_byte(m_data); tk = 1; end
            3: begin
              if (m_full) begin q_byte(m_data); tk = 1; end
              else begin
                if (m_pend || ecmd) begin
                  ee = !crc_en;
                  if (crc_en) begin mk = 4; q_crc(m_crc); end
                  else begin mk = 0; ipos = 0; end
                end else begin
                  eu = 1;
                  ee = udr_crc_en && !crc_en;
                  if (udr_crc_en && crc_en) begin mk = 4; q_crc(m_crc); end
                  else begin mk = 0; ipos = 0; end
                end
                m_pend = 0;
                ecmd = 0;
              end
            end
            default: begin mk = 0; ipos = 0; end
          endcase
        end
      end
      if (ecmd) m_pend = 1;
      if (eu) m_udr = 1; else if (st_clr[0]) m_udr = 0;
      if (ee) m_eomf = 1; else if (st_clr[1]) m_eomf = 0;
      if (tk) m_full = 0;
      acc_evt = s_valid && rdy;
      if (acc_evt) begin m_full = 1; m_data = s_data; end
    end
  end

  // per-clock comparison
  always @(posedge clk) begin
    logic e_rdy, e_irq;
    #1;
    if (rst_n) begin
      e_rdy = !m_full && tx_en && !m_udr;
      e_irq = (m_udr && udr_ie) || (m_eomf && eom_ie);
      n_cmp++;
      if (txd !== m_txd || s_ready !== e_rdy || udr_flag !== m_udr ||
          eom_flag !== m_eomf || irq !== e_irq) begin
        n_bad++;
        $display("FAIL %s t=%0t txd/rdy/udr/eom/irq=%b%b%b%b%b expected %b%b%b%b%b",
                 phase, $time, txd, s_ready, udr_flag, eom_flag, irq,
                 m_txd, e_rdy, m_udr, m_eomf, e_irq);
      end
    end
  end

  task automatic chk(string req, logic act, logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(logic [7:0] b);
    @(negedge clk); s_valid = 1'b1; s_data = b;
    do begin @(posedge clk); #1; end while (!acc_evt);
    @(negedge clk); s_valid = 1'b0;
  endtask

  task automatic eom_pulse();
    @(negedge clk); eom_cmd = 1'b1;
    @(negedge clk); eom_cmd = 1'b0;
  endtask

  task automatic clr(logic [1:0] b);
    @(negedge clk); st_clr = b;
    @(negedge clk); st_clr = 2'b00;
  endtask

  task automatic wait_active();
    while (mk == 0) @(negedge clk);
  endtask

  task automatic wait_idle();
    while (!(mk == 0 && !m_full)) @(negedge clk);
    cyc(20);
  endtask

  task automatic wait_udr();
    while (!m_udr) @(negedge clk);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL %s: watchdog expired, got running expected finished", phase);
    summary();
    $finish;
  end

  initial begin
    rst_n = 0; tx_en = 1; crc_en = 1; udr_crc_en = 0; idle_sel = 0;
    udr_ie = 1; eom_ie = 1; idle_pat = 8'b1101_0010; sync_a = 8'h16;
    sync_b = 8'h2D; s_valid = 0; s_data = 0; eom_cmd = 0; st_clr = 0;
    cyc(5);
    rst_n = 1;
    cyc(1);
    chk("R1 txd", txd, 1'b1);
    chk("R1 s_ready", s_ready, 1'b1);
    chk("R1 udr_flag", udr_flag, 1'b0);
    chk("R1 irq", irq, 1'b0);

    phase = "R2"; bdiv = 2;
    cyc(40);
    idle_sel = 1; cyc(70);

    phase = "R3,R5"; bdiv = 1;
    send(8'hA5); wait_active(); send(8'h3C); send(8'h81); eom_pulse();
    wait_idle();
    chk("R5 no irq after CRC end", irq, 1'b0);

    phase = "R4"; tx_en = 0;
    @(negedge clk); s_valid = 1; s_data = 8'hEE;
    cyc(30);
    chk("R4 ready low when disabled", s_ready, 1'b0);
    s_valid = 0; tx_en = 1; cyc(20);

    phase = "R6"; crc_en = 0; bdiv = 3;
    send(8'h5A); wait_active(); send(8'hC3); eom_pulse(); wait_idle();
    chk("R6 eom_flag", eom_flag, 1'b1);
    chk("R6 irq", irq, 1'b1);
    phase = "R12";
    clr(2'b01);
    chk("R12 eom kept by udr clear", eom_flag, 1'b1);
    clr(2'b10);
    chk("R12 eom cleared", eom_flag, 1'b0);

    phase = "R7,R8"; crc_en = 1; udr_crc_en = 1; bdiv = 2; idle_sel = 0;
    send(8'h11); wait_active(); send(8'hF0);
    wait_udr(); cyc(1);
    chk("R7 udr_flag", udr_flag, 1'b1);
    chk("R7 ready low", s_ready, 1'b0);
    chk("R7 irq", irq, 1'b1);
    wait_idle();
    phase = "R9";
    @(negedge clk); s_valid = 1; s_data = 8'h77;
    cyc(60);
    chk("R9 still flagged", udr_flag, 1'b1);
    s_valid = 0;
    clr(2'b01);
    chk("R9 flag cleared", udr_flag, 1'b0);
    send(8'h77); wait_active(); eom_pulse(); wait_idle();

    phase = "R8"; udr_crc_en = 0; idle_sel = 1;
    send(8'h42); wait_udr(); wait_idle();
    chk("R8 no eom flag", eom_flag, 1'b0);
    clr(2'b01);
    udr_crc_en = 1; crc_en = 0;
    send(8'h99); wait_udr(); wait_idle();
    chk("R8 eom flag on udr", eom_flag, 1'b1);
    clr(2'b11);

    phase = "R10"; crc_en = 1; udr_crc_en = 0; bdiv = 1;
    eom_pulse(); cyc(5);
    send(8'h24); wait_udr(); wait_idle();
    chk("R10 ignored command gives underrun", udr_flag, 1'b1);
    clr(2'b01);

    phase = "R11"; bdiv = 2;
    send(8'h01); wait_active(); send(8'h80); eom_pulse(); send(8'h6B);
    wait_idle();
    chk("R11 no underrun", udr_flag, 1'b0);

    summary();
    $finish;
  end
endmodule